// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block keeps the eight-bit status byte of a serial NOR flash and rules on every state-changing request before the array engine sees it. The command decoder sends it one decoded operation per cycle, with the status-write data byte and the 24-bit target address. The block also sees the level of the active-low write-protect pin. For each program, erase or status-write request it answers with a one-cycle grant or reject. A granted request raises the busy bit, and the busy bit stays up until the array engine returns a completion pulse.

Protection works at two levels. A four-bit protect code selects a power-of-two group of 64 KB sectors at the top of the array, and program and erase requests aimed into that group are refused. A lock bit, combined with a low write-protect pin, freezes the lock bit and the protect code against status writes. A sticky fail bit records an array operation that ended in error and stays set until the next write request arrives.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte is 00h, and grant and reject are low.
- R2: Command code 1 (enable) sets the write-enable bit (bit 1) and code 2 (disable) clears it, in the cycle after the command, when the busy bit is clear. Codes 0 (idle) and 4 (status read) leave the status byte unchanged.
- R3: A write-type request (code 3 status write, 5 page program, 6 sector erase, 7 chip erase) made while bit 1 is 0 is rejected. reject_o pulses in the next cycle, and the busy bit (bit 0) stays 0.
- R4: A granted status write loads bit 7 and bits 5:2 from the data byte and sets the busy bit. Bits 0, 1 and 6 are never taken from the data byte.
- R5: While the lock bit (bit 7) is 1 and wp_ni is 0, a status write is rejected, and bits 7 and 5:2 keep their values.
- R6: For protect code P (bits 5:2), a page program or sector erase is rejected when the target sector is protected. The sector index is address bits 22:16. For P in 1..6 the protected sectors are indices 128-2^P through 127. For P of 7 or more all sectors are protected. For P of 0 no sector is protected.
- R7: A chip erase is rejected when any protect bit is set.
- R8: The busy bit stays 1 until done_i is seen. In the cycle after done_i, the busy bit and the write-enable bit both read 0.
- R9: The fail bit (bit 6) is set when done_i arrives with fail_i high for a program or erase. A status-write cycle never sets it. Any write-type request made while idle clears it, whether the request is granted or rejected.
- R10: While the busy bit is 1, every write-type request is rejected, and codes 1 and 2 are ignored. The status byte changes only through done_i.
- R11: grant_o and reject_o are never high together. A write-type request made while idle produces exactly one of them in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_op_i | input | 3 | Decoded command code, 0 meaning none |
| wr_data_i | input | 8 | Data byte of a status write |
| addr_i | input | 24 | Target byte address of a program or erase |
| wp_ni | input | 1 | Write-protect pin level, active low |
| done_i | input | 1 | Completion pulse from the array engine |
| fail_i | input | 1 | Error flag, valid with done_i |
| status_o | output | 8 | Full status byte |
| grant_o | output | 1 | Request accepted, one-cycle pulse |
| reject_o | output | 1 | Request refused, one-cycle pulse |
| wip_o | output | 1 | Busy bit |
| wel_o | output | 1 | Write-enable bit |
| fail_o | output | 1 | Sticky fail bit |

## Verification
The bench probes the edges of each protect range, for example sectors 125 and 126 under code 1 and sectors 63 and 64 under code 6. An off-by-one decoder would program a sector that should be guarded, or refuse one that should not be. A status write is tried with the lock bit set and the pin low, and a design that ignored the pin would let the protect code be overwritten. Enable commands and completion pulses are issued while busy, which catches a design that lets enable slip through mid-cycle or drops busy early. A faulty status-write completion is sent to confirm that only program and erase set the fail bit, and a rejected request is sent afterwards to confirm that it still clears that bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_WREN   = 3'd1,
    CMD_WRDI   = 3'd2,
    CMD_WRSR   = 3'd3,
    CMD_RDSR   = 3'd4,
    CMD_PROG   = 3'd5,
    CMD_SERASE = 3'd6,
    CMD_CERASE = 3'd7
  } cmd_e;

  localparam int unsigned BIT_WIP  = 0;
  localparam int unsigned BIT_WEL  = 1;
  localparam int unsigned BIT_BP_L = 2;
  localparam int unsigned BIT_BP_H = 5;
  localparam int unsigned BIT_FAIL = 6;
  localparam int unsigned BIT_LOCK = 7;
  localparam int unsigned BP_W     = BIT_BP_H - BIT_BP_L + 1;

  // status bits a status write may load
  localparam logic [7:0] WRSR_MASK = 8'b1011_1100;
endpackage

// File: rtl/sreg_prot_decode.sv
module sreg_prot_decode
  import sreg_pkg::*;
#(
  parameter int unsigned SEC_W = 7
) (
  input  logic [BP_W-1:0]  bp_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic             hit_o,
  output logic             any_o
);
  localparam int unsigned NUM_SEC = 1 << SEC_W;
  localparam int unsigned CW      = SEC_W + 1;

  // hit_vec[k]: sector lies in the top 2^k sectors
  logic [SEC_W:0] hit_vec;

  assign hit_vec[0]     = 1'b0;
  assign hit_vec[SEC_W] = 1'b1;

  for (genvar k = 1; k < SEC_W; k++) begin : g_band
    localparam logic [CW-1:0] BASE = CW'(NUM_SEC - (1 << k));
    assign hit_vec[k] = {1'b0, sec_i} >= BASE;
  end

  always_comb begin
    if (32'(bp_i) >= SEC_W) hit_o = 1'b1;
    else                    hit_o = hit_vec[bp_i];
  end

  assign any_o = |bp_i;
endmodule

// File: rtl/sreg_cmd_check.sv
module sreg_cmd_check
  import sreg_pkg::*;
(
  input  cmd_e op_i,
  input  logic wip_i,
  input  logic wel_i,
  input  logic lock_i,
  input  logic wp_ni,
  input  logic prot_hit_i,
  input  logic prot_any_i,
  output logic wr_type_o,
  output logic grant_o,
  output logic reject_o
);
  always_comb begin
    unique case (op_i)
      CMD_WRSR, CMD_PROG, CMD_SERASE, CMD_CERASE: wr_type_o = 1'b1;
      default:                                    wr_type_o = 1'b0;
    endcase
  end

  always_comb begin
    grant_o  = 1'b0;
    reject_o = 1'b0;
    if (wr_type_o) begin
      if (wip_i || !wel_i) begin
        reject_o = 1'b1;
      end else begin
        unique case (op_i)
          CMD_WRSR:            reject_o = lock_i && !wp_ni;
          CMD_PROG, CMD_SERASE: reject_o = prot_hit_i;
          CMD_CERASE:          reject_o = prot_any_i;
          default:             reject_o = 1'b1;
        endcase
        grant_o = !reject_o;
      end
    end
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned SEC_LSB = 16,
  parameter int unsigned SEC_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_op_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_ni,
  input  logic              done_i,
  input  logic              fail_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              wip_o,
  output logic              wel_o,
  output logic              fail_o
);
  localparam int unsigned SEC_MSB = SEC_LSB + SEC_W - 1;

  cmd_e       op;
  logic [7:0] sr_q, sr_d;
  logic       pe_q, pe_d;
  logic       grant_q, reject_q;
  logic       wr_type, grant_c, reject_c;
  logic       prot_hit, prot_any;

  assign op = cmd_e'(cmd_op_i);

  sreg_prot_decode #(.SEC_W(SEC_W)) i_prot (
    .bp_i  (sr_q[BIT_BP_H:BIT_BP_L]),
    .sec_i (addr_i[SEC_MSB:SEC_LSB]),
    .hit_o (prot_hit),
    .any_o (prot_any)
  );

  sreg_cmd_check i_check (
    .op_i       (op),
    .wip_i      (sr_q[BIT_WIP]),
    .wel_i      (sr_q[BIT_WEL]),
    .lock_i     (sr_q[BIT_LOCK]),
    .wp_ni      (wp_ni),
    .prot_hit_i (prot_hit),
    .prot_any_i (prot_any),
    .wr_type_o  (wr_type),
    .grant_o    (grant_c),
    .reject_o   (reject_c)
  );

  always_comb begin
    sr_d = sr_q;
    pe_d = pe_q;
    if (sr_q[BIT_WIP]) begin
      if (done_i) begin
        sr_d[BIT_WIP] = 1'b0;
        sr_d[BIT_WEL] = 1'b0;
        if (pe_q && fail_i) sr_d[BIT_FAIL] = 1'b1;
      end
    end else begin
      if (op == CMD_WREN) sr_d[BIT_WEL] = 1'b1;
      if (op == CMD_WRDI) sr_d[BIT_WEL] = 1'b0;
      if (wr_type)        sr_d[BIT_FAIL] = 1'b0;
      if (grant_c) begin
        sr_d[BIT_WIP] = 1'b1;
        pe_d          = (op != CMD_WRSR);
        if (op == CMD_WRSR)
          sr_d = (sr_d & ~WRSR_MASK) | (wr_data_i & WRSR_MASK);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      pe_q     <= 1'b0;
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      pe_q     <= pe_d;
      grant_q  <= grant_c;
      reject_q <= reject_c;
    end
  end

  assign status_o = sr_q;
  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign wip_o    = sr_q[BIT_WIP];
  assign wel_o    = sr_q[BIT_WEL];
  assign fail_o   = sr_q[BIT_FAIL];

  assert_one_verdict_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_q && reject_q));

  assert_grant_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_q[BIT_WIP]) |-> grant_q);

  assert_no_wel_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_q[BIT_WIP] && wr_type && !sr_q[BIT_WEL]) |=> (reject_q && !sr_q[BIT_WIP]));

  assert_hw_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_q[BIT_WIP] && op == CMD_WRSR && sr_q[BIT_LOCK] && !wp_ni)
      |=> (reject_q && $stable({sr_q[BIT_LOCK], sr_q[BIT_BP_H:BIT_BP_L]})));

  assert_sector_guard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_q[BIT_WIP] && (op == CMD_PROG || op == CMD_SERASE) && prot_hit) |=> reject_q);

  assert_chip_guard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_q[BIT_WIP] && op == CMD_CERASE && prot_any) |=> reject_q);

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q[BIT_WIP] && !done_i) |=> sr_q[BIT_WIP]);

  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q[BIT_WIP] && done_i) |=> (!sr_q[BIT_WIP] && !sr_q[BIT_WEL]));

  assert_busy_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q[BIT_WIP] && !done_i) |=> $stable(sr_q));

  assert_fail_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sr_q[BIT_FAIL]) |-> $past(done_i && fail_i && pe_q));
endmodule

// File: tb/test_sreg_guard.sv
module test_sreg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [23:0] addr_i = '0;
  logic        wp_ni = 1'b1;
  logic        done_i = 1'b0;
  logic        fail_i = 1'b0;
  logic [7:0]  status_o;
  logic        grant_o, reject_o, wip_o, wel_o, fail_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] m_sr = '0;
  logic       m_pe = 1'b0;
  logic       e_grant = 1'b0, e_reject = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sreg_guard i_sreg_guard (
    .clk_i, .rst_ni, .cmd_op_i, .wr_data_i, .addr_i, .wp_ni, .done_i, .fail_i,
    .status_o, .grant_o, .reject_o, .wip_o, .wel_o, .fail_o
  );

  function automatic bit is_wr(input logic [2:0] op);
    return op == 3 || op == 5 || op == 6 || op == 7;
  endfunction

  function automatic bit sec_prot(input logic [3:0] bp, input logic [6:0] sec);
    if (bp == 0) return 0;
    if (bp >= 7) return 1;
    return int'(sec) >= 128 - (1 << bp);
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [7:0] sr,
                                   input logic wp, input logic dn);
    if (sr[0]) return dn ? "R8" : "R10";
    if (!is_wr(op)) return "R2";
    if (!sr[1]) return "R3";
    if (op == 3) return (sr[7] && !wp) ? "R5" : "R4";
    if (op == 7) return "R7";
    return "R6";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [7:0] d, input logic [23:0] a,
                      input logic wp, input logic dn, input logic fl);
    logic [7:0] nsr;
    string tg;
    cmd_op_i = op; wr_data_i = d; addr_i = a; wp_ni = wp; done_i = dn; fail_i = fl;
    tg = tag_of(op, m_sr, wp, dn);
    nsr = m_sr; e_grant = 0; e_reject = 0;
    if (m_sr[0]) begin
      if (is_wr(op)) e_reject = 1;
      if (dn) begin
        nsr[0] = 0; nsr[1] = 0;
        if (m_pe && fl) nsr[6] = 1;
      end
    end else begin
      if (op == 1) nsr[1] = 1;
      if (op == 2) nsr[1] = 0;
      if (is_wr(op)) begin
        nsr[6] = 0;
        if (!m_sr[1]) e_reject = 1;
        else if (op == 3) e_reject = m_sr[7] && !wp;
        else if (op == 7) e_reject = |m_sr[5:2];
        else e_reject = sec_prot(m_sr[5:2], a[22:16]);
        e_grant = !e_reject;
        if (e_grant) begin
          nsr[0] = 1;
          m_pe = (op != 3);
          if (op == 3) begin nsr[7] = d[7]; nsr[5:2] = d[5:2]; end
        end
      end
    end
    m_sr = nsr;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tg, "status", int'(status_o), int'(m_sr));
    check(tg, "grant", int'(grant_o), int'(e_grant));
    check(tg, "reject", int'(reject_o), int'(e_reject));
    check("R9", "fail", int'(fail_o), int'(m_sr[6]));
    check("R11", "both", int'(grant_o && reject_o), 0);
    check(tg, "wip/wel", int'({wip_o, wel_o}), int'({m_sr[0], m_sr[1]}));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "reset status", int'(status_o), 0);
    check("R1", "reset verdict", int'({grant_o, reject_o}), 0);

    // write without enable
    step(5, 8'h00, 24'h000000, 1, 0, 0);               // R3
    // lock with protect code 1, then try to unlock with pin low
    step(1, 0, 0, 1, 0, 0);
    step(3, 8'h84, 0, 1, 0, 0);                        // R4
    step(1, 0, 0, 1, 0, 0);                            // R10 ignored
    step(0, 0, 0, 1, 1, 1);                            // R8, R9 status write no fail
    step(1, 0, 0, 1, 0, 0);
    step(3, 8'h00, 0, 0, 0, 0);                        // R5
    // range edge for code 1
    step(5, 0, 24'h7D0000, 0, 0, 0);                   // R6 sector 125 ok
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    step(5, 0, 24'h7E0000, 0, 0, 0);                   // R6 sector 126 blocked
    step(7, 0, 0, 0, 0, 0);                            // R7
    // code 6 edge, unlocked via pin high
    step(3, 8'h18, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(1, 0, 0, 1, 0, 0);
    step(6, 0, 24'h3F0000, 1, 0, 0);                   // R6 sector 63 ok
    step(3, 8'h00, 0, 1, 0, 0);                        // R10 rejected busy
    step(0, 0, 0, 1, 1, 1);                            // R9 fail set
    step(2, 0, 0, 1, 0, 0);
    step(6, 0, 24'h400000, 1, 0, 0);                   // R3 reject clears fail (R9)
    step(1, 0, 0, 1, 0, 0);
    step(6, 0, 24'h400000, 1, 0, 0);                   // R6 sector 64 blocked
    step(3, 8'h1C, 0, 1, 0, 0);                        // code 7
    step(0, 0, 0, 1, 1, 0);
    step(1, 0, 0, 1, 0, 0);
    step(5, 0, 24'h000000, 1, 0, 0);                   // R6 whole array
    step(3, 8'h00, 0, 1, 0, 0);
    step(4, 0, 0, 1, 0, 0);                            // R2 read no effect
    step(0, 0, 0, 1, 1, 0);
    step(1, 0, 0, 1, 0, 0);
    step(7, 0, 0, 1, 0, 0);                            // R7 granted with code 0
    step(0, 0, 0, 1, 1, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] op;
      logic dn;
      op = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) op = 3'd1;
      dn = m_sr[0] ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 7) == 0);
      step(op, 8'($urandom), 24'($urandom), 1'($urandom_range(0, 1)), dn,
           1'($urandom_range(0, 1)));
    end
    finish_run();
  end
endmodule